// File: doc/BRIEF.md
# Serial ADC Power-Managed Conversion Controller

This block is the host-side master for a 10-bit, single-channel serial converter that is driven by an active-low chip select and a serial clock. It runs conversion frames, collects the serial result, and steers the converter between running and powered-down states purely through the moment at which chip select is released within a frame. The serial clock rate is set by a runtime divider. A runtime quiet gap is held after every frame.

The user side offers two one-cycle requests: read one sample, or power down. The controller tracks what it believes the converter's power state to be. Whenever a read or a power-down needs the converter awake and that state is not known to be running, it first issues a throw-away frame and discards its result. A read produces a 10-bit word together with a one-cycle valid strobe. A power-down produces a one-cycle done strobe and no valid.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: After reset `cs_n_o`=1, `sclk_o`=1, `busy_o`=0, `valid_o`=0, `done_o`=0 and `pstate_o`=0 (unknown).
- R2: A read frame has 16 falling SCLK edges while chip select is low. Each SCLK half period is `div_i`+1 clock cycles, so chip select stays low for exactly 32·(`div_i`+1) cycles.
- R3: The bit present on `sdata_i` at the r-th rising SCLK edge of a frame (r = 1..16) is stream position r. Positions 4..13 form the result, most significant bit first. `data_o` carries that word, and `valid_o` is high for exactly one cycle: the cycle in which `cs_n_o` returns high.
- R4: A read requested while `pstate_o` is unknown or shutdown first runs one complete throw-away frame that raises no `valid_o`, and then runs the real frame. Each read yields exactly one `valid_o` pulse.
- R5: `pstate_o` uses the encoding 0 unknown, 1 shutdown, 2 waking, 3 running. It reads 2 while a throw-away frame is pending or running. It reads 3 after any complete frame and 1 after a power-down frame.
- R6: A power-down requested in the running state raises `cs_n_o` in the same cycle as the 12th falling SCLK edge. Chip select is therefore low for 23·(`div_i`+1) cycles. The request gives one `done_o` pulse in that cycle and no `valid_o`.
- R7: A power-down requested in the shutdown state runs no frame and pulses `done_o` once. A power-down requested in the unknown state runs a throw-away frame and then the shortened frame.
- R8: `busy_o` is high whenever chip select is low. After the last frame of a request, `busy_o` stays high for exactly `quiet_i`+1 cycles from the cycle in which `cs_n_o` rises. It is high throughout the gap between a throw-away frame and the frame that follows it.
- R9: Requests that arrive while `busy_o` is high have no effect. When both requests arrive together on an idle controller, only the read is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | SCLK half period minus one, in clock cycles |
| quiet_i | input | QW | Quiet gap after each frame minus one, in clock cycles |
| rd_req_i | input | 1 | Request one conversion |
| sd_req_i | input | 1 | Request converter power-down |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| data_o | output | RES_W | Last valid conversion result |
| valid_o | output | 1 | One-cycle strobe for `data_o` |
| done_o | output | 1 | One-cycle strobe: power-down complete |
| busy_o | output | 1 | Frame or quiet gap in progress; requests ignored |
| pstate_o | output | 2 | Tracked converter power state |

## Verification
Reads, power-downs and repeat power-downs are swept over every divider value from 0 to 2 and over short and long quiet gaps. The sweep shows that chip-select length, edge count and gap length scale with the settings, and it separates the full frame (16 edges) from the shortened one (12 edges). Each read starts from a different power state (unknown, running, shutdown). These cases tell apart one frame from a throw-away frame plus a real one, and a single valid from zero or two. Result words include all-ones, a single low bit and mixed patterns, which expose bit order and field offset. Requests made mid-frame and simultaneous requests separate the hold-off rule from the priority rule.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;
  localparam int NFALL   = 16;
  localparam int RES_W   = 10;
  localparam int LEAD    = 3;
  localparam int SD_FALL = 12;

  typedef enum logic [1:0] {
    PS_UNKNOWN  = 2'd0,
    PS_SHUTDOWN = 2'd1,
    PS_WAKING   = 2'd2,
    PS_NORMAL   = 2'd3
  } pstate_e;

  typedef enum logic [1:0] {
    K_DUMMY = 2'd0,
    K_READ  = 2'd1,
    K_SD    = 2'd2
  } kind_e;

  // result field out of a stream where the first sampled bit is the MSB
  function automatic logic [RES_W-1:0] frame_word(input logic [NFALL-1:0] s, input int lead);
    logic [NFALL-1:0] t;
    t = s >> (NFALL - lead - RES_W);
    return t[RES_W-1:0];
  endfunction

  // cycles with chip select low for a frame that ends after `halves` toggles
  function automatic int low_cycles(input int div, input int halves);
    return halves * (div + 1);
  endfunction
endpackage

// File: rtl/adc_frame_seq.sv
module adc_frame_seq #(
  parameter int DIV_W   = 4,
  parameter int QW      = 4,
  parameter int NFALL   = 16,
  parameter int SD_FALL = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             partial,
  input  logic [DIV_W-1:0] div_i,
  input  logic [QW-1:0]    quiet_i,
  output logic             cs_n,
  output logic             sclk,
  output logic             fall_ev,
  output logic             rise_ev,
  output logic             end_ev,
  output logic             quiet_end,
  output logic             busy
);
  localparam int NW = $clog2(NFALL + 1);

  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_QUIET} sq_e;

  sq_e              st;
  logic [DIV_W-1:0] hcnt;
  logic [QW-1:0]    qcnt;
  logic [NW-1:0]    nfall;
  logic             cs_q, sclk_q, part_q;
  logic             tog_ev, cut_ev;

  assign tog_ev    = (st == SQ_RUN) && (hcnt == div_i);
  assign fall_ev   = tog_ev && sclk_q;
  assign rise_ev   = tog_ev && !sclk_q;
  assign cut_ev    = fall_ev && part_q && (nfall + NW'(1) == NW'(SD_FALL));
  assign end_ev    = (rise_ev && nfall == NW'(NFALL)) || cut_ev;
  assign quiet_end = (st == SQ_QUIET) && (qcnt == quiet_i);
  assign busy      = (st != SQ_IDLE);
  assign cs_n      = cs_q;
  assign sclk      = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
      hcnt   <= '0;
      qcnt   <= '0;
      nfall  <= '0;
      part_q <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: if (start) begin
          st     <= SQ_RUN;
          cs_q   <= 1'b0;
          sclk_q <= 1'b1;
          hcnt   <= '0;
          nfall  <= '0;
          part_q <= partial;
        end
        SQ_RUN: if (tog_ev) begin
          hcnt   <= '0;
          sclk_q <= !sclk_q;
          if (fall_ev) nfall <= nfall + NW'(1);
          if (end_ev) begin
            cs_q <= 1'b1;
            st   <= SQ_QUIET;
            qcnt <= '0;
          end
        end else begin
          hcnt <= hcnt + DIV_W'(1);
        end
        SQ_QUIET: begin
          sclk_q <= 1'b1;
          if (quiet_end) st <= SQ_IDLE;
          else qcnt <= qcnt + QW'(1);
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift #(
  parameter int  NFALL          = 16,
  parameter bit  SAMPLE_ON_FALL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_ev,
  input  logic             rise_ev,
  input  logic             sdata_i,
  output logic [NFALL-1:0] stream_nxt
);
  logic [NFALL-1:0] shift_q;
  logic             samp_ev;

  assign samp_ev    = SAMPLE_ON_FALL ? fall_ev : rise_ev;
  assign stream_nxt = {shift_q[NFALL-2:0], sdata_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else if (samp_ev) shift_q <= stream_nxt;
  end
endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
  import adc_pwr_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int QW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic [QW-1:0]    quiet_i,
  input  logic             rd_req_i,
  input  logic             sd_req_i,
  input  logic             sdata_i,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic [RES_W-1:0] data_o,
  output logic             valid_o,
  output logic             done_o,
  output logic             busy_o,
  output logic [1:0]       pstate_o
);
  logic             fall_ev, rise_ev, end_ev, quiet_end, seq_busy;
  logic [NFALL-1:0] stream_nxt;
  logic             go, pend_v, acc_rd, acc_sd;
  kind_e            kind, pend_k;
  pstate_e          pstate;

  adc_frame_seq #(.DIV_W(DIV_W), .QW(QW), .NFALL(NFALL), .SD_FALL(SD_FALL)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(go), .partial(kind == K_SD),
    .div_i(div_i), .quiet_i(quiet_i), .cs_n(cs_n_o), .sclk(sclk_o),
    .fall_ev(fall_ev), .rise_ev(rise_ev), .end_ev(end_ev),
    .quiet_end(quiet_end), .busy(seq_busy)
  );

  adc_rx_shift #(.NFALL(NFALL), .SAMPLE_ON_FALL(1'b0)) u_rx (
    .clk(clk), .rst_n(rst_n), .fall_ev(fall_ev), .rise_ev(rise_ev),
    .sdata_i(sdata_i), .stream_nxt(stream_nxt)
  );

  assign busy_o   = seq_busy | go | pend_v;
  assign acc_rd   = rd_req_i && !busy_o;
  assign acc_sd   = sd_req_i && !busy_o && !rd_req_i;
  assign pstate_o = pstate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pstate  <= PS_UNKNOWN;
      go      <= 1'b0;
      kind    <= K_READ;
      pend_v  <= 1'b0;
      pend_k  <= K_READ;
      valid_o <= 1'b0;
      done_o  <= 1'b0;
      data_o  <= '0;
    end else begin
      go      <= 1'b0;
      valid_o <= 1'b0;
      done_o  <= 1'b0;
      if (acc_rd) begin
        go <= 1'b1;
        if (pstate == PS_NORMAL) begin
          kind <= K_READ;
        end else begin
          kind   <= K_DUMMY;
          pend_v <= 1'b1;
          pend_k <= K_READ;
          pstate <= PS_WAKING;
        end
      end else if (acc_sd) begin
        case (pstate)
          PS_NORMAL: begin
            go   <= 1'b1;
            kind <= K_SD;
          end
          PS_SHUTDOWN: done_o <= 1'b1;
          default: begin
            go     <= 1'b1;
            kind   <= K_DUMMY;
            pend_v <= 1'b1;
            pend_k <= K_SD;
            pstate <= PS_WAKING;
          end
        endcase
      end
      if (end_ev) begin
        case (kind)
          K_DUMMY: pstate <= PS_NORMAL;
          K_READ: begin
            valid_o <= 1'b1;
            data_o  <= frame_word(stream_nxt, LEAD);
          end
          default: begin
            pstate <= PS_SHUTDOWN;
            done_o <= 1'b1;
          end
        endcase
      end
      if (quiet_end && pend_v) begin
        go     <= 1'b1;
        kind   <= pend_k;
        pend_v <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_pwr_ctrl_chk.sv
module adc_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n_o,
  input logic       sclk_o,
  input logic       valid_o,
  input logic       done_o,
  input logic       busy_o,
  input logic [1:0] pstate_o
);
  a_r8_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> busy_o);
  a_r3_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  a_r3_valid_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (cs_n_o && $past(!cs_n_o)));
  a_r6_done_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !valid_o);
  a_r5_valid_when_running: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (pstate_o == 2'd3));
  a_r9_start_only_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> $past(busy_o));
  a_r2_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_o && $past(cs_n_o)) |-> sclk_o);
endmodule

bind adc_pwr_ctrl adc_pwr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
  .valid_o(valid_o), .done_o(done_o), .busy_o(busy_o), .pstate_o(pstate_o)
);

// File: tb/tb_adc_pwr_ctrl.sv
module tb_adc_pwr_ctrl;
  localparam int DIV_W = 3;
  localparam int QW    = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] div_i = '0;
  logic [QW-1:0]    quiet_i = '0;
  logic             rd_req = 1'b0, sd_req = 1'b0;
  logic             sdata = 1'b0;
  logic             cs_n, sclk, valid, done, busy;
  logic [9:0]       data;
  logic [1:0]       pstate;

  adc_pwr_ctrl #(.DIV_W(DIV_W), .QW(QW)) dut (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .quiet_i(quiet_i),
    .rd_req_i(rd_req), .sd_req_i(sd_req), .sdata_i(sdata),
    .cs_n_o(cs_n), .sclk_o(sclk), .data_o(data), .valid_o(valid),
    .done_o(done), .busy_o(busy), .pstate_o(pstate)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [9:0] adc_val = '0;

  // monitor and converter model, sampled away from the active edge
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  int falls = 0, lowlen = 0, nframes = 0, last_falls = 0, last_low = 0;
  int nvalid = 0, ndone = 0, tail = 0;
  logic [9:0] last_data = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n && prev_cs) begin
        falls = 0; lowlen = 0; nframes++; tail = 0;
      end
      if (!cs_n) lowlen++;
      if (prev_sclk && !sclk && !prev_cs) begin
        falls++;
        if (!cs_n && falls >= 1 && falls <= 16) begin
          logic [15:0] st;
          st = {3'b000, adc_val, 3'b000};
          sdata = st[16 - falls];
        end
      end
      if (cs_n && !prev_cs) begin
        last_falls = falls; last_low = lowlen; tail = 0;
      end
      if (cs_n && busy) tail++;
      if (valid) begin nvalid++; last_data = data; end
      if (done) ndone++;
      prev_cs = cs_n; prev_sclk = sclk;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  int d_frames, d_valid, d_done;
  task automatic run_op(input logic r, input logic s, input bit mid);
    int f0, v0, n0;
    f0 = nframes; v0 = nvalid; n0 = ndone;
    @(negedge clk); rd_req = r; sd_req = s;
    @(negedge clk); rd_req = 1'b0; sd_req = 1'b0;
    if (mid) begin
      repeat (10) @(negedge clk);
      rd_req = 1'b1; sd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0; sd_req = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    d_frames = nframes - f0; d_valid = nvalid - v0; d_done = ndone - n0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    check(cs_n == 1'b1 && sclk == 1'b1, "R1 cs/sclk idle", {cs_n, sclk}, 3);
    check(!busy && !valid && !done, "R1 strobes low", {busy, valid, done}, 0);
    check(pstate == 2'd0, "R1 pstate unknown", pstate, 0);

    for (int d = 0; d < 3; d++) begin
      for (int qi = 0; qi < 2; qi++) begin
        int q;
        q = (qi == 0) ? 0 : 5;
        div_i = DIV_W'(d); quiet_i = QW'(q);

        // read: from unknown on first pass, from running otherwise
        adc_val = 10'((d * 211 + q * 77 + 10'h155) & 10'h3FF);
        run_op(1'b1, 1'b0, 1'b0);
        check(d_frames == ((d == 0 && qi == 0) ? 2 : 1), "R4 frame count of read", d_frames,
              (d == 0 && qi == 0) ? 2 : 1);
        check(d_valid == 1, "R4 one valid per read", d_valid, 1);
        check(last_data == adc_val, "R3 result word", last_data, adc_val);
        check(last_falls == 16, "R2 falling edges", last_falls, 16);
        check(last_low == 32 * (d + 1), "R2 cs low cycles", last_low, 32 * (d + 1));
        check(tail == q + 1, "R8 quiet tail", tail, q + 1);
        check(pstate == 2'd3, "R5 running after read", pstate, 3);

        // power-down from running
        run_op(1'b0, 1'b1, 1'b0);
        check(d_frames == 1 && last_falls == 12, "R6 shortened frame edges", last_falls, 12);
        check(last_low == 23 * (d + 1), "R6 cs low cycles", last_low, 23 * (d + 1));
        check(d_valid == 0 && d_done == 1, "R6 done without valid", d_valid * 10 + d_done, 1);
        check(tail == q + 1, "R8 quiet tail after power-down", tail, q + 1);
        check(pstate == 2'd1, "R5 shutdown state", pstate, 1);

        // power-down again while already down
        run_op(1'b0, 1'b1, 1'b0);
        check(d_frames == 0 && d_done == 1, "R7 no frame when down", d_frames * 10 + d_done, 1);

        // read from shutdown
        adc_val = (d == 1) ? 10'h3FF : 10'(10'h3FF ^ (10'h1 << (d * 3 + qi)));
        run_op(1'b1, 1'b0, 1'b0);
        check(d_frames == 2 && d_valid == 1, "R4 wake read frames", d_frames * 10 + d_valid, 21);
        check(last_data == adc_val, "R3 result after wake", last_data, adc_val);
        check(pstate == 2'd3, "R5 running after wake", pstate, 3);
      end
    end

    // requests while busy are ignored
    adc_val = 10'h001;
    run_op(1'b1, 1'b0, 1'b1);
    check(d_frames == 1 && d_valid == 1 && d_done == 0, "R9 mid-frame requests ignored",
          d_frames * 100 + d_valid * 10 + d_done, 110);
    check(pstate == 2'd3 && last_data == 10'h001, "R9 state kept", pstate, 3);

    // both requests at once: read wins
    adc_val = 10'h2C3;
    run_op(1'b1, 1'b1, 1'b0);
    check(d_valid == 1 && d_done == 0 && last_falls == 16, "R9 read priority",
          d_valid * 10 + d_done, 10);
    check(last_data == 10'h2C3, "R3 result on priority read", last_data, 10'h2C3);

    // power-down from unknown
    do_reset();
    check(pstate == 2'd0, "R1 pstate after second reset", pstate, 0);
    run_op(1'b0, 1'b1, 1'b0);
    check(d_frames == 2 && last_falls == 12, "R7 throw-away then shortened",
          d_frames * 100 + last_falls, 212);
    check(d_valid == 0 && d_done == 1, "R7 done only", d_valid * 10 + d_done, 1);
    check(pstate == 2'd1, "R5 shutdown from unknown", pstate, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end
endmodule